// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port memory and watches the left and right access requests. A collision is a cycle in which both ports are enabled and present the same address. The port whose access started earlier keeps the location. The other port is told to wait through an active-low busy output and a write-block output. If both accesses start in the same cycle, a fixed tie-break gives the location to the left port. The winner keeps the location until the collision ends, which happens when either port drops its enable or moves to another address.

For word-width expansion several of these blocks run side by side. One is strapped as master and computes busy itself. The others are strapped as slaves: their busy outputs stay inactive and they take the master's busy decision on two input pins. A slave uses that decision only to block writes. Because the master's decision takes a few cycles to settle, a slave also blocks writes for a settle window after each new access starts on a port.

The arbiter is a state machine with five states. `ARB_IDLE` means no collision is being handled. `ARB_WAIT_L` and `ARB_WAIT_R` mean the left or the right port has won and the busy delay is still counting. `ARB_HOLD_L` and `ARB_HOLD_R` mean the left or the right port has won and busy is asserted to the loser.

The state transitions are:
- `ARB_IDLE` goes to a `WAIT` state when a collision appears (or straight to a `HOLD` state when the busy delay is one cycle).
- A `WAIT` state goes to the matching `HOLD` state when its delay count runs out.
- Any state goes back to `ARB_IDLE` when the collision ends or the block is strapped as slave.

Top module: `dp_contention_arbiter`

## Requirements
- R1: Busy and write-block are raised only when both enables are high and the two addresses are equal. Otherwise, in master mode, both busy outputs stay 1 and both write-block outputs stay 0.
- R2: When one port's access started in an earlier cycle than the other's, the earlier port wins and the busy output of the later port is driven to 0. An access starts when the enable rises or the address changes while the port is enabled.
- R3: When both accesses start in the same cycle, the left port wins and `rt_busy_n` is driven to 0.
- R4: Let the clock edge that first samples a collision be edge 1. The loser's busy output goes to 0 on edge BUSY_DLY and is 1 before that edge. This also holds when the collision is created by an enable rising on an address that already matches.
- R5: The two busy outputs are never 0 at the same time.
- R6: Busy stays 0 while the collision lasts. It returns to 1 on the first edge that samples no collision, including when the winner changes its address.
- R7: In master mode, the loser's write-block output is 1 in every cycle of a collision, starting in the first cycle before any edge. The winner's write-block output stays 0.
- R8: In slave mode (`master_mode` = 0), both busy outputs stay 1. A port's write-block output is 1 when that port's busy input is 0, and also for BUSY_DLY cycles beginning with the cycle in which that port's access starts.
- R9: After reset, with both enables low, both busy outputs are 1 and both write-block outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1 = compute busy (master), 0 = take busy from master (slave) |
| lt_en | input | 1 | Left port access enable |
| lt_addr | input | ADDR_W | Left port address |
| rt_en | input | 1 | Right port access enable |
| rt_addr | input | ADDR_W | Right port address |
| lt_busy_in_n | input | 1 | Slave mode: master's busy for the left port, active low |
| rt_busy_in_n | input | 1 | Slave mode: master's busy for the right port, active low |
| lt_busy_n | output | 1 | Busy to the left port, active low, registered |
| rt_busy_n | output | 1 | Busy to the right port, active low, registered |
| lt_wr_block | output | 1 | Inhibits writes from the left port |
| rt_wr_block | output | 1 | Inhibits writes from the right port |

## Verification
Inputs are driven on the falling edge, so the first rising edge after a stimulus samples it. The write-block outputs are combinational and are checked 1 ns after the stimulus, before that edge. The busy outputs are registered. With the bench's BUSY_DLY of 2, busy is checked as still 1 after the first rising edge and as 0 after the second. Busy release is checked one falling edge after the collision ends. The slave settle window is checked as active on the stimulus cycle and the next cycle, and as clear after the second rising edge.

// File: rtl/dpca_pkg.sv
package dpca_pkg;

    typedef enum logic [2:0] {
        ARB_IDLE   = 3'd0,
        ARB_WAIT_L = 3'd1,
        ARB_WAIT_R = 3'd2,
        ARB_HOLD_L = 3'd3,
        ARB_HOLD_R = 3'd4
    } arb_state_e;

endpackage

// File: rtl/dpca_port_track.sv
module dpca_port_track #(
    parameter int ADDR_W   = 8,
    parameter int BUSY_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              start,
    output logic              settling
);
    localparam int SW = $clog2(BUSY_DLY + 1);

    logic              en_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SW-1:0]     cnt_q;

    // a new access: enable rising, or address moving while enabled
    assign start    = en && (!en_q || (addr != addr_q));
    assign settling = start || (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            en_q   <= en;
            addr_q <= addr;
            if (start)
                cnt_q <= SW'(BUSY_DLY - 1);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // R8
    settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < BUSY_DLY);

endmodule

// File: rtl/dpca_addr_match.sv
module dpca_addr_match #(
    parameter int ADDR_W = 8
) (
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              hit
);
    assign hit = l_en && r_en && (l_addr == r_addr);
endmodule

// File: rtl/dpca_arb_fsm.sv
module dpca_arb_fsm
    import dpca_pkg::*;
#(
    parameter int BUSY_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic hit,
    input  logic start_l,
    input  logic start_r,
    output logic busy_l_n,
    output logic busy_r_n,
    output logic block_l,
    output logic block_r
);
    localparam int CW = (BUSY_DLY > 1) ? $clog2(BUSY_DLY) : 1;

    arb_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          left_first;

    // left wins unless it alone is the newer access (ties go left)
    assign left_first = !(start_l && !start_r);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!master || !hit) begin
            state_d = ARB_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ARB_IDLE: begin
                    cnt_d = CW'(BUSY_DLY - 1);
                    if (BUSY_DLY == 1)
                        state_d = left_first ? ARB_HOLD_L : ARB_HOLD_R;
                    else
                        state_d = left_first ? ARB_WAIT_L : ARB_WAIT_R;
                end
                ARB_WAIT_L: begin
                    if (cnt_q <= CW'(1)) begin
                        state_d = ARB_HOLD_L;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ARB_WAIT_R: begin
                    if (cnt_q <= CW'(1)) begin
                        state_d = ARB_HOLD_R;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ARB_HOLD_L: state_d = ARB_HOLD_L;
                ARB_HOLD_R: state_d = ARB_HOLD_R;
                default:    state_d = ARB_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered busy outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_l_n <= 1'b1;
            busy_r_n <= 1'b1;
        end else begin
            busy_l_n <= (state_d != ARB_HOLD_R);
            busy_r_n <= (state_d != ARB_HOLD_L);
        end
    end

    // write inhibit covers the pending and the settled phase
    always_comb begin
        block_l = 1'b0;
        block_r = 1'b0;
        if (master && hit) begin
            unique case (state_q)
                ARB_IDLE: begin
                    block_l = !left_first;
                    block_r = left_first;
                end
                ARB_WAIT_L, ARB_HOLD_L: block_r = 1'b1;
                ARB_WAIT_R, ARB_HOLD_R: block_l = 1'b1;
                default: ;
            endcase
        end
    end

    // R5
    one_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!busy_l_n && !busy_r_n));

    // R6
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit) |=> (busy_l_n && busy_r_n));

    // R3
    tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && hit && state_q == ARB_IDLE && start_l && start_r)
        |=> (state_q == ARB_WAIT_L || state_q == ARB_HOLD_L));

    // R4
    delay_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < BUSY_DLY);

endmodule

// File: rtl/dp_contention_arbiter.sv
module dp_contention_arbiter #(
    parameter int ADDR_W   = 8,
    parameter int BUSY_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              lt_en,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              rt_en,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              lt_busy_in_n,
    input  logic              rt_busy_in_n,
    output logic              lt_busy_n,
    output logic              rt_busy_n,
    output logic              lt_wr_block,
    output logic              rt_wr_block
);
    localparam int NPORT = 2;

    logic [NPORT-1:0]             en_v;
    logic [NPORT-1:0][ADDR_W-1:0] addr_v;
    logic [NPORT-1:0]             start_v;
    logic [NPORT-1:0]             settle_v;
    logic                         hit;
    logic                         m_block_l, m_block_r;

    assign en_v   = {rt_en, lt_en};
    assign addr_v = {rt_addr, lt_addr};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpca_port_track #(.ADDR_W(ADDR_W), .BUSY_DLY(BUSY_DLY)) u_track (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en_v[p]),
            .addr     (addr_v[p]),
            .start    (start_v[p]),
            .settling (settle_v[p])
        );
    end

    dpca_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .l_en   (lt_en),
        .l_addr (lt_addr),
        .r_en   (rt_en),
        .r_addr (rt_addr),
        .hit    (hit)
    );

    dpca_arb_fsm #(.BUSY_DLY(BUSY_DLY)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .master   (master_mode),
        .hit      (hit),
        .start_l  (start_v[0]),
        .start_r  (start_v[1]),
        .busy_l_n (lt_busy_n),
        .busy_r_n (rt_busy_n),
        .block_l  (m_block_l),
        .block_r  (m_block_r)
    );

    assign lt_wr_block = master_mode ? m_block_l : (!lt_busy_in_n || settle_v[0]);
    assign rt_wr_block = master_mode ? m_block_r : (!rt_busy_in_n || settle_v[1]);

    // R8
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode) |=> (lt_busy_n && rt_busy_n));

    // R7
    single_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master_mode |-> !(lt_wr_block && rt_wr_block));

    // R1
    no_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !hit) |-> (!lt_wr_block && !rt_wr_block));

endmodule

// File: tb/dp_contention_arbiter_test.sv
module dp_contention_arbiter_test;
    localparam int AW  = 3;
    localparam int DLY = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_mode = 1'b1;
    logic          lt_en = 1'b0, rt_en = 1'b0;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic          lt_busy_in_n = 1'b1, rt_busy_in_n = 1'b1;
    logic          lt_busy_n, rt_busy_n, lt_wr_block, rt_wr_block;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    dp_contention_arbiter #(.ADDR_W(AW), .BUSY_DLY(DLY)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .master_mode  (master_mode),
        .lt_en        (lt_en),
        .lt_addr      (lt_addr),
        .rt_en        (rt_en),
        .rt_addr      (rt_addr),
        .lt_busy_in_n (lt_busy_in_n),
        .rt_busy_in_n (rt_busy_in_n),
        .lt_busy_n    (lt_busy_n),
        .rt_busy_n    (rt_busy_n),
        .lt_wr_block  (lt_wr_block),
        .rt_wr_block  (rt_wr_block)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic idle_ports();
        @(negedge clk);
        lt_en = 1'b0;
        rt_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got hung expected finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 lt_busy_n", lt_busy_n, 1'b1);
        chk("R9 rt_busy_n", rt_busy_n, 1'b1);
        chk("R9 lt_wr_block", lt_wr_block, 1'b0);
        chk("R9 rt_wr_block", rt_wr_block, 1'b0);

        // sweep: same-cycle starts over every enable/address combination (R1 R3 R4)
        for (int le = 0; le < 2; le++)
            for (int re = 0; re < 2; re++)
                for (int a = 0; a < (1 << AW); a++)
                    for (int b = 0; b < (1 << AW); b++) begin
                        logic hit;
                        hit = (le == 1) && (re == 1) && (a == b);
                        @(negedge clk);
                        lt_en = le[0]; rt_en = re[0];
                        lt_addr = AW'(a); rt_addr = AW'(b);
                        #1;
                        chk("R7 rt_wr_block early", rt_wr_block, hit);
                        chk("R1 lt_wr_block", lt_wr_block, 1'b0);
                        @(negedge clk);
                        chk("R4 rt_busy_n before delay", rt_busy_n, 1'b1);
                        @(negedge clk);
                        chk("R3 rt_busy_n tie", rt_busy_n, !hit);
                        chk("R1 lt_busy_n", lt_busy_n, 1'b1);
                        @(negedge clk);
                        lt_en = 1'b0; rt_en = 1'b0;
                        @(negedge clk);
                        chk("R6 rt_busy_n release", rt_busy_n, 1'b1);
                    end

        // left first, right enables onto the same address (R2 R4 R6)
        @(negedge clk); lt_en = 1'b1; lt_addr = 3'd5;
        @(negedge clk); rt_en = 1'b1; rt_addr = 3'd5;
        #1;
        chk("R7 rt_wr_block loser", rt_wr_block, 1'b1);
        chk("R7 lt_wr_block winner", lt_wr_block, 1'b0);
        @(negedge clk);
        chk("R4 rt_busy_n pending", rt_busy_n, 1'b1);
        @(negedge clk);
        chk("R2 rt_busy_n left first", rt_busy_n, 1'b0);
        chk("R5 lt_busy_n", lt_busy_n, 1'b1);
        repeat (3) @(negedge clk);
        chk("R6 rt_busy_n held", rt_busy_n, 1'b0);
        lt_en = 1'b0;
        @(negedge clk);
        chk("R6 rt_busy_n after winner leaves", rt_busy_n, 1'b1);
        chk("R6 rt_wr_block after release", rt_wr_block, 1'b0);
        idle_ports();

        // right first (R2)
        @(negedge clk); rt_en = 1'b1; rt_addr = 3'd2;
        @(negedge clk); lt_en = 1'b1; lt_addr = 3'd2;
        #1;
        chk("R7 lt_wr_block loser", lt_wr_block, 1'b1);
        chk("R7 rt_wr_block winner", rt_wr_block, 1'b0);
        repeat (2) @(negedge clk);
        chk("R2 lt_busy_n right first", lt_busy_n, 1'b0);
        chk("R2 rt_busy_n right first", rt_busy_n, 1'b1);
        idle_ports();

        // right moves onto left's address: right is newer, left wins (R2)
        @(negedge clk); lt_en = 1'b1; lt_addr = 3'd1; rt_en = 1'b1; rt_addr = 3'd2;
        @(negedge clk); rt_addr = 3'd1;
        repeat (2) @(negedge clk);
        chk("R2 rt_busy_n addr move", rt_busy_n, 1'b0);
        // winner changes address (R6)
        lt_addr = 3'd3;
        @(negedge clk);
        chk("R6 rt_busy_n winner moved", rt_busy_n, 1'b1);
        idle_ports();

        // left moves onto right's address: right wins
        @(negedge clk); lt_en = 1'b1; lt_addr = 3'd6; rt_en = 1'b1; rt_addr = 3'd7;
        @(negedge clk); lt_addr = 3'd7;
        repeat (2) @(negedge clk);
        chk("R2 lt_busy_n addr move", lt_busy_n, 1'b0);
        idle_ports();

        // slave mode (R8)
        @(negedge clk); master_mode = 1'b0;
        @(negedge clk); lt_en = 1'b1; lt_addr = 3'd4; rt_en = 1'b1; rt_addr = 3'd4;
        #1;
        chk("R8 lt_wr_block settle start", lt_wr_block, 1'b1);
        chk("R8 rt_wr_block settle start", rt_wr_block, 1'b1);
        @(negedge clk);
        chk("R8 lt_wr_block settle", lt_wr_block, 1'b1);
        @(negedge clk);
        chk("R8 lt_wr_block settled", lt_wr_block, 1'b0);
        chk("R8 rt_wr_block settled", rt_wr_block, 1'b0);
        chk("R8 lt_busy_n slave", lt_busy_n, 1'b1);
        chk("R8 rt_busy_n slave", rt_busy_n, 1'b1);
        lt_busy_in_n = 1'b0;
        #1;
        chk("R8 lt_wr_block busy in", lt_wr_block, 1'b1);
        chk("R8 rt_wr_block other port", rt_wr_block, 1'b0);
        @(negedge clk); lt_busy_in_n = 1'b1; rt_busy_in_n = 1'b0;
        #1;
        chk("R8 lt_wr_block busy gone", lt_wr_block, 1'b0);
        chk("R8 rt_wr_block busy in", rt_wr_block, 1'b1);
        @(negedge clk); rt_busy_in_n = 1'b1;
        idle_ports();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule